// File: doc/BRIEF.md
# DDR Write Burst Strobe Capture

This block takes in the data of one write burst on a DDR memory interface, where each data element is framed by a source-synchronous strobe. A memory controller pulses `wr_cmd` for one system clock when it issues a write. The block then opens a timing window and waits for the first low-to-high strobe transition. That transition carries data element 0. Each strobe transition after it, falling or rising, carries the next element, until the burst length is reached. When the burst is complete the block drops back to idle. Strobe and data that arrive after that have no effect until the next command.

Strobe and data are sampled by a system clock that runs `OSR` times faster than the memory clock. Strobe edges are found by comparing successive samples, so the whole block is plain synchronous logic. If the first rising edge arrives too early or too late, the block flags a window error and drops that burst. A complete burst is presented as one packed word together with a one-cycle done pulse.

Timing convention used below: edge E0 is the system clock edge that samples `wr_cmd` high. A strobe "arrives at k" when `dqs_in` is first sampled high at edge E0+k. With the defaults (`OSR`=8, `SYNC_DEPTH`=1), the accepted window is LO = ceil(0.75·OSR) = 6 to HI = floor(1.25·OSR) = 10.

Top module: `ddr_write_capture`

## Requirements
- R1: While reset is held, and after it is released with no command applied, `burst_data` is all zeros and `done` and `win_err` are low.
- R2: A first rising strobe edge arriving at k with LO ≤ k ≤ HI (6..10 by default) is accepted, and the data sampled with it becomes element 0.
- R3: After acceptance, every further strobe transition of either polarity stores the next element. Element i occupies `burst_data[i*DATA_W +: DATA_W]`, so element 0 sits in the least significant bits.
- R4: `done` is a single-cycle pulse. It is high in the cycle that follows edge t+1, where t is the edge that first samples the strobe level carrying the last element. It is never high together with `win_err`.
- R5: `burst_data` changes only in a cycle in which `done` is high, and it then holds the complete burst.
- R6: A first rising edge arriving at k < LO raises `win_err` for exactly the cycle after edge E0+k+1. No element of that burst is stored and no `done` follows.
- R7: If no rising edge has been seen by the end of the window, `win_err` is high for exactly the cycle after edge E0+HI+1. A strobe that arrives later is ignored.
- R8: Once a burst has completed, strobe transitions and data seen before the next command change neither `burst_data` nor `done`.
- R9: A `wr_cmd` that arrives while the block waits for a first edge or captures a burst discards the partial burst and restarts the window from the new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, OSR times the memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cmd | input | 1 | One-cycle pulse marking a write command |
| dqs_in | input | 1 | Data strobe from the bus |
| dq_in | input | DATA_W | Write data from the bus |
| burst_data | output | BURST_LEN*DATA_W | Assembled burst, element 0 in the low bits |
| done | output | 1 | One-cycle pulse when a burst is complete |
| win_err | output | 1 | One-cycle pulse when the first strobe edge falls outside the window |

## Verification
Suppose the window counter is off by one, or starts from the wrong cycle. Then a strobe at k = LO−1, LO, HI or HI+1 lands on the wrong side of the window, and the bench sees it within a few cycles as a missing `done` or an unexpected `win_err`. It catches this because it sweeps every arrival time from 1 to HI+2. If the element index slips, or the partial burst is not cleared on a restart, `burst_data` shows swapped or stale bytes at the very `done` cycle. Capture that is not shut off after a burst shows up as a second `done`, or a changed word, within one strobe period of the extra edges.

// File: rtl/ddrwc_pkg.sv
package ddrwc_pkg;

   // Control phases of the capture sequencer
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // no burst pending, bus ignored
      ST_WAIT = 2'd1,   // command seen, looking for first rising strobe
      ST_CAPT = 2'd2    // collecting elements on every strobe transition
   } cap_state_t;

   // Earliest accepted arrival (in system cycles) of the first rising edge
   function automatic int win_lo(input int osr, input int sync_depth);
      return (3 * osr + 3) / 4 + sync_depth - 1;
   endfunction

   // Latest accepted arrival of the first rising edge
   function automatic int win_hi(input int osr, input int sync_depth);
      return (5 * osr) / 4 + sync_depth - 1;
   endfunction

endpackage

// File: rtl/ddrwc_sampler.sv
module ddrwc_sampler #(
   parameter int DATA_W     = 8,
   parameter int SYNC_DEPTH = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dqs_in,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rise,
   output logic              fall,
   output logic [DATA_W-1:0] dq_s
);

   // dqs_pipe[0] is the newest sample; the top bit is one sample older than
   // the one aligned with dq_s.
   logic [SYNC_DEPTH:0]                dqs_pipe;
   logic [SYNC_DEPTH-1:0][DATA_W-1:0]  dq_pipe;

   generate
      if (SYNC_DEPTH == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dqs_pipe <= '0;
               dq_pipe  <= '0;
            end else begin
               dqs_pipe <= {dqs_pipe[0], dqs_in};
               dq_pipe  <= dq_in;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dqs_pipe <= '0;
               dq_pipe  <= '0;
            end else begin
               dqs_pipe <= {dqs_pipe[SYNC_DEPTH-1:0], dqs_in};
               dq_pipe  <= {dq_pipe[SYNC_DEPTH-2:0], dq_in};
            end
         end
      end
   endgenerate

   assign rise = dqs_pipe[SYNC_DEPTH-1] & ~dqs_pipe[SYNC_DEPTH];
   assign fall = ~dqs_pipe[SYNC_DEPTH-1] & dqs_pipe[SYNC_DEPTH];
   assign dq_s = dq_pipe[SYNC_DEPTH-1];

   // R3
   rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

   // R3
   fall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/ddrwc_window.sv
module ddrwc_window
   import ddrwc_pkg::*;
#(
   parameter int OSR        = 8,
   parameter int SYNC_DEPTH = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic waiting,
   input  logic rise,
   output logic first_ok,
   output logic first_early,
   output logic expired
);

   localparam int LO = win_lo(OSR, SYNC_DEPTH);
   localparam int HI = win_hi(OSR, SYNC_DEPTH);
   localparam int CW = $clog2(HI + 1);

   logic [CW-1:0] cnt;

   // Counts system cycles since the command edge; saturates at the last
   // accepted arrival so the expiry decode is a single compare.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (waiting && (cnt != CW'(HI))) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign first_early = waiting & rise & (cnt <  CW'(LO));
   assign first_ok    = waiting & rise & (cnt >= CW'(LO));
   assign expired     = waiting & ~rise & (cnt == CW'(HI));

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(HI));

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && !restart && (cnt < CW'(HI))) |=> (cnt == $past(cnt) + 1'b1));

   // R9
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));

endmodule

// File: rtl/ddrwc_assembler.sv
module ddrwc_assembler #(
   parameter int DATA_W    = 8,
   parameter int BURST_LEN = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clear,
   input  logic                          wr_en,
   input  logic [DATA_W-1:0]             din,
   output logic                          last,
   output logic [BURST_LEN*DATA_W-1:0]   word_next
);

   localparam int IW = $clog2(BURST_LEN);

   logic [IW-1:0] idx;

   assign last = wr_en & (idx == IW'(BURST_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clear) begin
         idx <= '0;
      end else if (wr_en) begin
         idx <= last ? '0 : idx + 1'b1;
      end
   end

   // One holding register per element; the element being written this
   // cycle is bypassed into word_next so the final element is included.
   generate
      for (genvar g = 0; g < BURST_LEN; g++) begin : g_slot
         logic [DATA_W-1:0] q;
         logic              hit;
         assign hit = wr_en & ~clear & (idx == IW'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (hit) begin
               q <= din;
            end
         end
         assign word_next[g*DATA_W +: DATA_W] = hit ? din : q;
      end
   endgenerate

   // R3
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= IW'(BURST_LEN - 1));

   // R3
   idx_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clear && !last) |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/ddr_write_capture.sv
module ddr_write_capture
   import ddrwc_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int BURST_LEN  = 4,
   parameter int OSR        = 8,
   parameter int SYNC_DEPTH = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_cmd,
   input  logic                        dqs_in,
   input  logic [DATA_W-1:0]           dq_in,
   output logic [BURST_LEN*DATA_W-1:0] burst_data,
   output logic                        done,
   output logic                        win_err
);

   localparam int WORD_W = BURST_LEN * DATA_W;

   // Elaboration-time parameter checks
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if ((BURST_LEN < 2) || (BURST_LEN % 2 != 0)) begin : g_bad_burst
         $error("BURST_LEN must be even and at least 2");
      end
      if (OSR < 8) begin : g_bad_osr
         $error("OSR must be at least 8");
      end
      if (SYNC_DEPTH < 1) begin : g_bad_sync
         $error("SYNC_DEPTH must be at least 1");
      end
   endgenerate

   cap_state_t          state_q;
   logic                rise, fall;
   logic [DATA_W-1:0]   dq_s;
   logic                first_ok, first_early, expired;
   logic                wr_en, last;
   logic [WORD_W-1:0]   word_next;
   logic                waiting, capturing;

   assign waiting   = (state_q == ST_WAIT);
   assign capturing = (state_q == ST_CAPT);

   ddrwc_sampler #(
      .DATA_W     (DATA_W),
      .SYNC_DEPTH (SYNC_DEPTH)
   ) u_sampler (
      .clk    (clk),
      .rst_n  (rst_n),
      .dqs_in (dqs_in),
      .dq_in  (dq_in),
      .rise   (rise),
      .fall   (fall),
      .dq_s   (dq_s)
   );

   ddrwc_window #(
      .OSR        (OSR),
      .SYNC_DEPTH (SYNC_DEPTH)
   ) u_window (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (wr_cmd),
      .waiting     (waiting),
      .rise        (rise),
      .first_ok    (first_ok),
      .first_early (first_early),
      .expired     (expired)
   );

   assign wr_en = ~wr_cmd & ((waiting & first_ok) | (capturing & (rise | fall)));

   ddrwc_assembler #(
      .DATA_W    (DATA_W),
      .BURST_LEN (BURST_LEN)
   ) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (wr_cmd),
      .wr_en     (wr_en),
      .din       (dq_s),
      .last      (last),
      .word_next (word_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         burst_data <= '0;
         done       <= 1'b0;
         win_err    <= 1'b0;
      end else begin
         done    <= 1'b0;
         win_err <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (wr_cmd) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (wr_cmd) begin
                  state_q <= ST_WAIT;
               end else if (first_ok) begin
                  state_q <= ST_CAPT;
               end else if (first_early || expired) begin
                  win_err <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_CAPT: begin
               if (wr_cmd) begin
                  state_q <= ST_WAIT;
               end else if (last) begin
                  burst_data <= word_next;
                  done       <= 1'b1;
                  state_q    <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && win_err));

   // R5
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(burst_data));

   // R6
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_err |-> (state_q == ST_IDLE));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !wr_cmd) |=> (!done && !win_err && state_q == ST_IDLE));

   // R9
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capturing && wr_cmd) |=> (waiting && !done));

endmodule

// File: tb/ddr_write_capture_test.sv
module ddr_write_capture_test;

   localparam int DW  = 8;
   localparam int BL  = 4;
   localparam int OSR = 8;
   localparam int HP  = OSR / 2;
   localparam int LO  = (3 * OSR + 3) / 4;
   localparam int HI  = (5 * OSR) / 4;

   logic              clk    = 1'b0;
   logic              rst_n  = 1'b0;
   logic              wr_cmd = 1'b0;
   logic              dqs    = 1'b0;
   logic [DW-1:0]     dq     = '0;
   wire  [BL*DW-1:0]  bd;
   wire               done;
   wire               werr;

   int checks = 0;
   int fails  = 0;
   int n_done = 0;
   int n_err  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   ddr_write_capture #(
      .DATA_W     (DW),
      .BURST_LEN  (BL),
      .OSR        (OSR),
      .SYNC_DEPTH (1)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_cmd     (wr_cmd),
      .dqs_in     (dqs),
      .dq_in      (dq),
      .burst_data (bd),
      .done       (done),
      .win_err    (werr)
   );

   // Pulse counters: value held during the cycle before each rising edge
   always @(posedge clk) begin
      if (rst_n) begin
         if (done) n_done++;
         if (werr) n_err++;
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] elem(input logic [7:0] seed, input int i);
      return DW'(seed * 5 + i * 37 + 3);
   endfunction

   function automatic logic [BL*DW-1:0] word_of(input logic [7:0] seed);
      logic [BL*DW-1:0] w;
      for (int i = 0; i < BL; i++) w[i*DW +: DW] = elem(seed, i);
      return w;
   endfunction

   // One write with the first rising strobe arriving at k (k >= 1)
   task automatic burst(input int k, input logic [7:0] seed);
      bit ok    = (k >= LO) && (k <= HI);
      bit early = (k < LO);
      int d0    = n_done;
      int e0    = n_err;
      logic [BL*DW-1:0] prev = bd;
      logic [BL*DW-1:0] after;
      wr_cmd = 1'b1;
      dqs    = 1'b0;
      step();                         // past E0
      wr_cmd = 1'b0;
      for (int j = 1; j < k; j++) begin
         step();                      // past E0+j
         if (j == HI + 1)
            check(werr == 1'b1, "R7 late window error pulse", 64'(werr), 64'd1);
      end
      dqs = 1'b1;
      dq  = elem(seed, 0);
      for (int t = 1; t <= (BL - 1) * HP + 3; t++) begin
         step();                      // past E0+k+t-1
         if ((t % HP == 0) && (t / HP < BL)) begin
            dqs = ~dqs;
            dq  = elem(seed, t / HP);
         end
         if (early && t == 2)
            check(werr == 1'b1, "R6 early window error pulse", 64'(werr), 64'd1);
         if (ok && t == (BL - 1) * HP + 1)
            check(done == 1'b0, "R4 done not before last element", 64'(done), 64'd0);
         if (ok && t == (BL - 1) * HP + 2) begin
            check(done == 1'b1, "R4 done timing", 64'(done), 64'd1);
            check(bd == word_of(seed), "R3 packed burst word",
                  64'(bd), 64'(word_of(seed)));
         end
         if (ok && t == (BL - 1) * HP + 3)
            check(done == 1'b0, "R4 done single cycle", 64'(done), 64'd0);
      end
      after = bd;
      // Extra strobe transitions after the burst must be ignored
      for (int x = 0; x < 2; x++) begin
         repeat (HP) step();
         dqs = ~dqs;
         dq  = ~elem(seed, x);
      end
      repeat (HP + 3) step();
      check(bd == after, "R8 data after burst ignored", 64'(bd), 64'(after));
      if (ok) begin
         check(n_done - d0 == 1, "R2 accepted arrival gives one done",
               64'(n_done - d0), 64'd1);
         check(n_err == e0, "R2 accepted arrival gives no error",
               64'(n_err - e0), 64'd0);
      end else begin
         check(n_done == d0, "R6/R7 rejected burst gives no done",
               64'(n_done - d0), 64'd0);
         check(n_err - e0 == 1, early ? "R6 one error" : "R7 one error",
               64'(n_err - e0), 64'd1);
         check(bd == prev, "R5 word held on rejected burst", 64'(bd), 64'(prev));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", fails, checks);
         $finish;
      end
   end

   initial begin
      int d0;
      repeat (3) step();
      check(bd == '0, "R1 word zero in reset", 64'(bd), 64'd0);
      check(done == 1'b0 && werr == 1'b0, "R1 pulses low in reset",
            64'({done, werr}), 64'd0);
      rst_n = 1'b1;
      // Strobe activity without a command must be ignored
      for (int x = 0; x < 4; x++) begin
         repeat (HP) step();
         dqs = ~dqs;
         dq  = DW'(x + 8'h5a);
      end
      repeat (4) step();
      check(bd == '0 && n_done == 0 && n_err == 0, "R1 idle after reset",
            64'(bd), 64'd0);

      // Sweep every arrival time across and beyond the window
      for (int s = 0; s < 2; s++)
         for (int k = 1; k <= HI + 2; k++)
            burst(k, 8'(k * 11 + s * 97));

      // R9: new command during capture discards the partial burst
      d0 = n_done;
      wr_cmd = 1'b1; step(); wr_cmd = 1'b0;
      repeat (7) step();
      dqs = 1'b1; dq = 8'hee;
      repeat (HP) step();
      dqs = 1'b0; dq = 8'hdd;
      repeat (2) step();
      burst(7, 8'h3c);
      check(n_done - d0 == 1, "R9 restart in capture one done",
            64'(n_done - d0), 64'd1);
      check(bd == word_of(8'h3c), "R9 restart in capture data",
            64'(bd), 64'(word_of(8'h3c)));

      // R9: new command while waiting restarts the window
      d0 = n_done;
      wr_cmd = 1'b1; step(); wr_cmd = 1'b0;
      repeat (8) step();
      burst(9, 8'hc7);
      check(n_done - d0 == 1, "R9 restart in wait accepted",
            64'(n_done - d0), 64'd1);
      check(bd == word_of(8'hc7), "R9 restart in wait data",
            64'(bd), 64'(word_of(8'hc7)));

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
   end

endmodule